// File: doc/BRIEF.md
# Shadow Screen Bank Access Control

This block holds the access-control register of a machine whose screen area is backed twice: once by main RAM and once by a shadow RAM bank. Both banks answer to the same screen window at 0x3000 to 0x7FFF. One register bit routes CPU reads and writes in that window to main or shadow RAM. A second, independent bit picks which bank the video fetch logic scans out.

Because the two choices are separate, software can draw into one buffer while the other is on screen. It then swaps both roles with a single register write that inverts both bits. The displayed-bank bit is taken up by the video path only when a frame begins, so a swap never splits a picture.

The block decodes the CPU address for register writes and readback. It steers the CPU and video addresses to a bank and drives one bank-select line for each path. RAM arrays and video timing sit outside it.

Top module: `shadow_access_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0x00, and both `cpu_bank_shadow` and `vid_bank_shadow` are 0 (main RAM) for every address.
- R2: A cycle with `cpu_wr`=1 and `cpu_addr`=0xFE34 stores all 8 bits of `cpu_wdata`. `reg_rdata` shows them from the next cycle, including the bits that have no function.
- R3: A write to any address other than 0xFE34 leaves the register unchanged.
- R4: When `cpu_addr` is inside 0x3000..0x7FFF, `cpu_bank_shadow` equals register bit 2 (1 = shadow RAM, 0 = main RAM).
- R5: When `cpu_addr` is outside 0x3000..0x7FFF, `cpu_bank_shadow` is 0 whatever the register holds.
- R6: Register bit 0 (1 = show shadow) is copied into the display latch only on a clock edge where `frame_start`=1. `vid_bank_shadow` follows the latch from the next cycle. A register write mid-frame does not change the displayed bank.
- R7: When `vid_addr` is outside 0x3000..0x7FFF, `vid_bank_shadow` is 0.
- R8: Writing the register with bits 0 and 2 both inverted moves CPU access to the other bank at once. The display moves to the other bank at the next frame start.
- R9: The window edges are inclusive: 0x3000 and 0x7FFF are inside, while 0x2FFF and 0x8000 are outside.
- R10: When a register write and `frame_start` fall on the same edge, the display latch takes bit 0 as it was before that write.
- R11: `reg_hit` is 1 exactly when `cpu_addr` equals 0xFE34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| vid_addr | input | 16 | Video fetch address |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| cpu_bank_shadow | output | 1 | CPU access goes to shadow RAM when 1 |
| vid_bank_shadow | output | 1 | Video fetch goes to shadow RAM when 1 |
| reg_hit | output | 1 | CPU address selects the control register |
| reg_rdata | output | 8 | Control register readback |

## Verification
Several rules are checked on every cycle by the assertions. The CPU and video paths must use main RAM outside the window. The CPU select must track bit 2 inside it. The register may change only on a write that hits it, and then holds the written byte. The display latch may move only on a frame pulse, and then takes the prior bit 0.

Other behaviour needs the directed scenarios. These cover the exact window edges, and a mid-frame write that leaves the picture alone. They also cover the one-write buffer swap followed by a frame, and a write that coincides with the frame pulse.

// File: rtl/shdw_pkg.sv
package shdw_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Control register layout: bit positions are decoded by the steering logic.
    typedef struct packed {
        logic [4:0] spare_hi;     // bits 7..3, stored and read back only
        logic       cpu_shadow;   // bit 2: CPU window access to shadow
        logic       spare_mid;    // bit 1, stored and read back only
        logic       disp_shadow;  // bit 0: display shadow bank
    } ctrl_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] lo,
                                       input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/shdw_ctrl_reg.sv
module shdw_ctrl_reg
    import shdw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    output ctrl_t             ctrl_q,
    output logic              hit
);
    assign hit = (addr == REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr && hit) begin
            ctrl_q <= ctrl_t'(wdata);
        end
    end
endmodule

// File: rtl/shdw_frame_latch.sv
module shdw_frame_latch (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (frame_start) begin
            q <= d;
        end
    end
endmodule

// File: rtl/shdw_steer.sv
module shdw_steer
    import shdw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_LO = 16'h3000,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'h7FFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              use_shadow,
    output logic              to_shadow
);
    always_comb begin
        to_shadow = use_shadow && in_window(addr, WIN_LO, WIN_HI);
    end
endmodule

// File: rtl/shadow_access_ctrl.sv
module shadow_access_ctrl
    import shdw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE34,
    parameter logic [ADDR_W-1:0] WIN_LO   = 16'h3000,
    parameter logic [ADDR_W-1:0] WIN_HI   = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] vid_addr,
    input  logic              frame_start,
    output logic              cpu_bank_shadow,
    output logic              vid_bank_shadow,
    output logic              reg_hit,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int N_PATHS = 2;  // 0: CPU, 1: video

    ctrl_t ctrl_q;
    logic  disp_q;

    logic [ADDR_W-1:0] path_addr [N_PATHS];
    logic              path_en   [N_PATHS];
    logic              path_out  [N_PATHS];

    shdw_ctrl_reg #(.REG_ADDR(REG_ADDR)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .wr     (cpu_wr),
        .ctrl_q (ctrl_q),
        .hit    (reg_hit)
    );

    shdw_frame_latch u_frame (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .d           (ctrl_q.disp_shadow),
        .q           (disp_q)
    );

    assign path_addr[0] = cpu_addr;
    assign path_en[0]   = ctrl_q.cpu_shadow;
    assign path_addr[1] = vid_addr;
    assign path_en[1]   = disp_q;

    for (genvar g = 0; g < N_PATHS; g++) begin : g_path
        shdw_steer #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_steer (
            .addr       (path_addr[g]),
            .use_shadow (path_en[g]),
            .to_shadow  (path_out[g])
        );
    end

    assign cpu_bank_shadow = path_out[0];
    assign vid_bank_shadow = path_out[1];
    assign reg_rdata       = DATA_W'(ctrl_q);
endmodule

// File: rtl/shdw_access_chk.sv
module shdw_access_chk
    import shdw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE34,
    parameter logic [ADDR_W-1:0] WIN_LO   = 16'h3000,
    parameter logic [ADDR_W-1:0] WIN_HI   = 16'h7FFF
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] vid_addr,
    input logic              frame_start,
    input logic              cpu_bank_shadow,
    input logic              vid_bank_shadow,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              disp_q
);
    AST_RESET_MAIN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_rdata == '0 && !disp_q)); // R1

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == REG_ADDR) |=> (reg_rdata == $past(cpu_wdata))); // R2

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_addr == REG_ADDR) |=> $stable(reg_rdata)); // R3

    AST_CPU_INSIDE: assert property (@(posedge clk) disable iff (rst)
        in_window(cpu_addr, WIN_LO, WIN_HI) |-> (cpu_bank_shadow == reg_rdata[2])); // R4

    AST_CPU_OUTSIDE_MAIN: assert property (@(posedge clk) disable iff (rst)
        !in_window(cpu_addr, WIN_LO, WIN_HI) |-> !cpu_bank_shadow); // R5

    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(disp_q)); // R6

    AST_DISP_LOAD: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (disp_q == $past(reg_rdata[0]))); // R10

    AST_VID_OUTSIDE_MAIN: assert property (@(posedge clk) disable iff (rst)
        !in_window(vid_addr, WIN_LO, WIN_HI) |-> !vid_bank_shadow); // R7
endmodule

bind shadow_access_ctrl shdw_access_chk #(
    .REG_ADDR(REG_ADDR), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cpu_addr        (cpu_addr),
    .cpu_wdata       (cpu_wdata),
    .cpu_wr          (cpu_wr),
    .vid_addr        (vid_addr),
    .frame_start     (frame_start),
    .cpu_bank_shadow (cpu_bank_shadow),
    .vid_bank_shadow (vid_bank_shadow),
    .reg_rdata       (reg_rdata),
    .disp_q          (disp_q)
);

// File: tb/sim_shadow_access_ctrl.sv
module sim_shadow_access_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic [15:0] vid_addr = '0;
    logic        frame_start = 1'b0;
    logic        cpu_bank_shadow;
    logic        vid_bank_shadow;
    logic        reg_hit;
    logic [7:0]  reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    shadow_access_ctrl u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .vid_addr(vid_addr), .frame_start(frame_start),
        .cpu_bank_shadow(cpu_bank_shadow), .vid_bank_shadow(vid_bank_shadow),
        .reg_hit(reg_hit), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge act, return at the next falling edge.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic frame);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; frame_start = frame;
        @(negedge clk);
        cpu_wr = 1'b0; frame_start = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic probe(input logic [15:0] ca, input logic [15:0] va);
        cpu_addr = ca; vid_addr = va;
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        probe(16'h5000, 16'h5000);
        check("R1 reg", {8'h0, reg_rdata}, 16'h0000);
        check("R1 cpu", {15'h0, cpu_bank_shadow}, 16'h0);
        check("R1 vid", {15'h0, vid_bank_shadow}, 16'h0);
    endtask

    task automatic t_readback();
        bus_write(16'hFE34, 8'hA5, 1'b0);
        check("R2 readback A5", {8'h0, reg_rdata}, 16'h00A5);
        bus_write(16'hFE34, 8'hFA, 1'b0);
        check("R2 readback FA", {8'h0, reg_rdata}, 16'h00FA);
    endtask

    task automatic t_other_addr();
        bus_write(16'hFE34, 8'h00, 1'b0);
        bus_write(16'hFE35, 8'hFF, 1'b0);
        check("R3 FE35 ignored", {8'h0, reg_rdata}, 16'h0000);
        bus_write(16'hFE30, 8'hFF, 1'b0);
        check("R3 FE30 ignored", {8'h0, reg_rdata}, 16'h0000);
        probe(16'hFE34, 16'h0);
        check("R11 hit FE34", {15'h0, reg_hit}, 16'h1);
        probe(16'hFE35, 16'h0);
        check("R11 miss FE35", {15'h0, reg_hit}, 16'h0);
    endtask

    task automatic t_cpu_steer();
        bus_write(16'hFE34, 8'h04, 1'b0);
        probe(16'h5000, 16'h0);
        check("R4 shadow on", {15'h0, cpu_bank_shadow}, 16'h1);
        probe(16'h2FFF, 16'h0);
        check("R9 2FFF out", {15'h0, cpu_bank_shadow}, 16'h0);
        probe(16'h3000, 16'h0);
        check("R9 3000 in", {15'h0, cpu_bank_shadow}, 16'h1);
        probe(16'h7FFF, 16'h0);
        check("R9 7FFF in", {15'h0, cpu_bank_shadow}, 16'h1);
        probe(16'h8000, 16'h0);
        check("R9 8000 out", {15'h0, cpu_bank_shadow}, 16'h0);
        probe(16'h0100, 16'h0);
        check("R5 low main", {15'h0, cpu_bank_shadow}, 16'h0);
        probe(16'hFFFF, 16'h0);
        check("R5 top main", {15'h0, cpu_bank_shadow}, 16'h0);
        bus_write(16'hFE34, 8'h00, 1'b0);
        probe(16'h5000, 16'h0);
        check("R4 shadow off", {15'h0, cpu_bank_shadow}, 16'h0);
    endtask

    task automatic t_video();
        bus_write(16'hFE34, 8'h01, 1'b0);
        probe(16'h0, 16'h4000);
        check("R6 no frame yet", {15'h0, vid_bank_shadow}, 16'h0);
        pulse_frame();
        probe(16'h0, 16'h4000);
        check("R6 after frame", {15'h0, vid_bank_shadow}, 16'h1);
        probe(16'h0, 16'h8000);
        check("R7 vid 8000", {15'h0, vid_bank_shadow}, 16'h0);
        probe(16'h0, 16'h2FFF);
        check("R7 vid 2FFF", {15'h0, vid_bank_shadow}, 16'h0);
        bus_write(16'hFE34, 8'h00, 1'b0);
        probe(16'h0, 16'h3000);
        check("R6 mid-frame hold", {15'h0, vid_bank_shadow}, 16'h1);
        pulse_frame();
        probe(16'h0, 16'h3000);
        check("R6 next frame", {15'h0, vid_bank_shadow}, 16'h0);
    endtask

    task automatic t_swap();
        logic [7:0] v;
        bus_write(16'hFE34, 8'h01, 1'b0);
        pulse_frame();
        v = reg_rdata ^ 8'h05;
        bus_write(16'hFE34, v, 1'b0);
        probe(16'h6000, 16'h6000);
        check("R8 cpu swapped", {15'h0, cpu_bank_shadow}, 16'h1);
        check("R8 vid waits", {15'h0, vid_bank_shadow}, 16'h1);
        pulse_frame();
        probe(16'h6000, 16'h6000);
        check("R8 vid swapped", {15'h0, vid_bank_shadow}, 16'h0);
    endtask

    task automatic t_coincide();
        bus_write(16'hFE34, 8'h00, 1'b0);
        pulse_frame();
        bus_write(16'hFE34, 8'h01, 1'b1);
        probe(16'h0, 16'h4000);
        check("R10 old bit latched", {15'h0, vid_bank_shadow}, 16'h0);
        pulse_frame();
        probe(16'h0, 16'h4000);
        check("R10 new bit next frame", {15'h0, vid_bank_shadow}, 16'h1);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_other_addr();
        t_cpu_steer();
        t_video();
        t_swap();
        t_coincide();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule